// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides one 32-bit integer by another over many clock cycles and returns only the quotient. Each operation can be signed or unsigned, chosen by a select input. The caller pulses `start` with the operands on the inputs. It then sees `busy` for the length of the computation and a one-cycle `done` pulse when the quotient appears on the output.

The divider never traps. When the divisor is zero, it divides by one instead, so the quotient equals the dividend. In signed mode, when the most negative value is divided by minus one, it also divides by one, so the quotient is the most negative value. Signed operation works on magnitudes with an unsigned shift-subtract loop and corrects the sign at the end.

Top module: `seq_divider`

## Requirements
- R1: With `is_signed` = 0 and a nonzero divisor, `quotient` is the floor of dividend / divisor, with both operands read as unsigned.
- R2: With `is_signed` = 1 and a divisor that is neither zero nor the overflow case, `quotient` is the two's-complement quotient truncated toward zero.
- R3: With `is_signed` = 0 and a divisor of 0, `quotient` equals the dividend.
- R4: With `is_signed` = 1 and a divisor of 0, `quotient` equals the dividend.
- R5: With `is_signed` = 1, a dividend of 32'h8000_0000 and a divisor of 32'hFFFF_FFFF, `quotient` is 32'h8000_0000.
- R6: A start is accepted on a rising edge where `start` = 1 and `busy` = 0. `done` is high for exactly one cycle, after the 33rd rising edge following the accepting edge.
- R7: `busy` rises after the accepting edge. It stays high until the edge on which `done` rises, and at that edge it falls.
- R8: A `start` that arrives while `busy` = 1 is ignored. The running operation keeps its operands and its `done` timing.
- R9: `quotient` changes only on the edge that raises `done`. It holds its value at all other times, including while a new operation runs.
- R10: A synchronous active-high `rst`, applied at any time, clears `busy`, `done` and `quotient` to 0 and abandons any running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division, accepted when not busy |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator, sampled on the accepting edge |
| divisor | input | 32 | Denominator, sampled on the accepting edge |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: quotient has just been updated |
| quotient | output | 32 | Registered quotient of the last completed operation |

## Verification
On every cycle, the bound checker tracks the handshake. It covers the single-cycle `done` pulse, the fixed 33-edge latency, `busy` clearing as `done` rises, and `quotient` holding outside `done`. It also latches the operands of each accepted start and checks the zero-divisor and signed-overflow results against them. General quotient correctness for signed and unsigned operands, rounding toward zero and sign handling are shown only by the bench's vector table. The same holds for ignoring a start during a run, back-to-back operation, and reset in mid-operation.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: substitute a divisor of one for the zero and
// signed-overflow cases, then take magnitudes and note the result sign.
module div_prep #(
  parameter int W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] mag_num,
  output logic [W-1:0] mag_den,
  output logic         neg
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic         den_zero, sgn_ovf, num_neg, den_neg;
  logic [W-1:0] den_eff;

  always_comb begin
    den_zero = (den == '0);
    sgn_ovf  = is_signed && (num == MOST_NEG) && (den == ALL_ONES);
    den_eff  = (den_zero || sgn_ovf) ? ONE : den;
    num_neg  = is_signed & num[W-1];
    den_neg  = is_signed & den_eff[W-1];
    mag_num  = num_neg ? (~num + ONE) : num;
    mag_den  = den_neg ? (~den_eff + ONE) : den_eff;
    neg      = num_neg ^ den_neg;
  end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: idle, W iteration cycles, one sign-fix cycle.
module div_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dstate_e       state;
  logic [CW-1:0] cnt;

  assign load   = start && (state == ST_IDLE);
  assign step   = (state == ST_RUN);
  assign finish = (state == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
          busy  <= 1'b1;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_datapath.sv
// Restoring shift-subtract datapath, one quotient bit per step.
module div_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mag_num,
  input  logic [W-1:0] mag_den,
  input  logic         neg_in,
  output logic [W-1:0] qbits,
  output logic         neg_q
);
  logic [W-1:0] rem, dvs;
  logic [W+1:0] shifted, diff;
  logic         fits;

  always_comb begin
    shifted = {1'b0, rem, qbits[W-1]};
    diff    = shifted - {2'b00, dvs};
    fits    = ~diff[W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      qbits <= '0;
      dvs   <= '0;
      neg_q <= 1'b0;
    end else if (load) begin
      rem   <= '0;
      qbits <= mag_num;
      dvs   <= mag_den;
      neg_q <= neg_in;
    end else if (step) begin
      rem   <= fits ? diff[W-1:0] : shifted[W-1:0];
      qbits <= {qbits[W-2:0], fits};
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  logic         load, step, finish, neg_in, neg_q;
  logic [W-1:0] mag_num, mag_den, qbits;

  div_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .num       (dividend),
    .den       (divisor),
    .mag_num   (mag_num),
    .mag_den   (mag_den),
    .neg       (neg_in)
  );

  div_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy)
  );

  div_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .mag_num (mag_num),
    .mag_den (mag_den),
    .neg_in  (neg_in),
    .qbits   (qbits),
    .neg_q   (neg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient <= '0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (finish) quotient <= neg_q ? (~qbits + 1'b1) : qbits;
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         is_signed,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient
);
  localparam int LAT = W + 1;
  localparam int LW  = $clog2(W + 4) + 1;
  localparam logic [LW-1:0] LATV = LW'(LAT);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [LW-1:0] lat_cnt;
  logic          cap_zero, cap_ovf;
  logic [W-1:0]  cap_num;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt  <= '0;
      cap_zero <= 1'b0;
      cap_ovf  <= 1'b0;
      cap_num  <= '0;
    end else if (start && !busy) begin
      lat_cnt  <= LW'(1);
      cap_zero <= (divisor == '0);
      cap_ovf  <= is_signed && (dividend == MOST_NEG) && (divisor == {W{1'b1}});
      cap_num  <= dividend;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (busy && lat_cnt == LATV) |=> done); // R6
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && lat_cnt != LATV) |=> !done); // R6
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R7
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(quotient)); // R9
  AST_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
    (done && cap_zero) |-> (quotient == cap_num)); // R3 R4
  AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && cap_ovf) |-> (quotient == MOST_NEG)); // R5
endmodule

bind seq_divider div_checker #(.W(W)) u_div_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .is_signed (is_signed),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  seq_divider #(.W(32)) dut (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  // {signed, dividend, divisor, expected quotient}
  localparam int NV = 16;
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 32'h0000_0064, 32'h0000_0007, 32'h0000_000E}, // R1
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF}, // R1
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0FFF_FFFF}, // R1
    {1'b0, 32'h0000_0005, 32'h0000_0009, 32'h0000_0000}, // R1
    {1'b0, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678}, // R3
    {1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000}, // R1
    {1'b1, 32'hFFFF_FFF9, 32'h0000_0002, 32'hFFFF_FFFD}, // R2
    {1'b1, 32'h0000_0007, 32'hFFFF_FFFE, 32'hFFFF_FFFD}, // R2
    {1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'h0000_0003}, // R2
    {1'b1, 32'h0000_0064, 32'h0000_0007, 32'h0000_000E}, // R2
    {1'b1, 32'hFFFF_FFFB, 32'h0000_0000, 32'hFFFF_FFFB}, // R4
    {1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000}, // R5
    {1'b1, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000}, // R2
    {1'b1, 32'h8000_0000, 32'h0000_0002, 32'hC000_0000}, // R2
    {1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001}, // R2
    {1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001}  // R2
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pre_wait=0 drives start at the current negedge (back-to-back use).
  // inject=1 pulses a conflicting start five cycles into the run.
  task automatic run_op(input bit pre_wait, input bit sgn, input logic [31:0] a,
                        input logic [31:0] b, input bit inject,
                        output logic [31:0] q, output int lat, output bit busy_ok);
    int n;
    if (pre_wait) @(negedge clk);
    is_signed = sgn; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_ok = 1'b1;
    n = 1;
    while (!done && n < 100) begin
      if (!busy) busy_ok = 1'b0;
      if (inject && n == 5) begin
        start = 1'b1; is_signed = 1'b0; dividend = 32'h0000_DEAD; divisor = 32'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (busy) busy_ok = 1'b0;
    lat = n - 1;
    q = quotient;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] q, held;
    int lat;
    bit bok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10 reset flags", {30'd0, busy, done}, 32'd0);
    check(quotient == 32'd0, "R10 reset quotient", quotient, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(1'b1, VEC[i][96], VEC[i][95:64], VEC[i][63:32], 1'b0, q, lat, bok);
      check(q == VEC[i][31:0], VEC[i][96] ? "R2/R4/R5 signed quotient" : "R1/R3 unsigned quotient",
            q, VEC[i][31:0]);
      check(lat == 33, "R6 latency", 32'(lat), 32'd33);
      check(bok, "R7 busy window", {31'd0, bok}, 32'd1);
    end

    // R6: done lasts one cycle; R9: quotient holds while idle with inputs moving
    held = quotient;
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", {31'd0, done}, 32'd0);
    dividend = 32'hAAAA_5555; divisor = 32'd0; is_signed = 1'b1;
    repeat (8) @(negedge clk);
    check(quotient == held, "R9 hold while idle", quotient, held);

    // R9: quotient holds during a new operation until its done
    is_signed = 1'b0; dividend = 32'd1000; divisor = 32'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(quotient == held, "R9 hold while running", quotient, held);
    while (!done) @(negedge clk);
    check(quotient == 32'd100, "R1 quotient after hold", quotient, 32'd100);

    // R8: start during a run is ignored
    run_op(1'b1, 1'b0, 32'd90, 32'd9, 1'b1, q, lat, bok);
    check(q == 32'd10, "R8 ignored start result", q, 32'd10);
    check(lat == 33, "R8 timing unchanged", 32'(lat), 32'd33);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R8 no second run", {30'd0, busy, done}, 32'd0);

    // back-to-back: new start in the done cycle is accepted
    run_op(1'b1, 1'b1, 32'hFFFF_FF9C, 32'd10, 1'b0, q, lat, bok);
    check(q == 32'hFFFF_FFF6, "R2 negative by positive", q, 32'hFFFF_FFF6);
    run_op(1'b0, 1'b0, 32'd77, 32'd11, 1'b0, q, lat, bok);
    check(q == 32'd7, "R1 back-to-back result", q, 32'd7);
    check(lat == 33 && bok, "R6 R7 back-to-back timing", 32'(lat), 32'd33);

    // R10: reset in mid-operation
    @(negedge clk);
    dividend = 32'd50; divisor = 32'd5; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10 mid-run reset flags", {30'd0, busy, done}, 32'd0);
    check(quotient == 32'd0, "R10 mid-run reset quotient", quotient, 32'd0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 run abandoned", {30'd0, busy, done}, 32'd0);
    run_op(1'b1, 1'b0, 32'd50, 32'd5, 1'b0, q, lat, bok);
    check(q == 32'd10, "R10 recovery", q, 32'd10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule